// File: doc/BRIEF.md
# Input Parity Error Flag

This block registers a 16-bit input word together with its parity bit and checks the pair for odd parity. The result drives a sticky error flag. The flag changes only on an error-phase strobe, and only while the error-clock enable is high. On that strobe it either takes the new check result, or, when checking is disabled, holds its present value through feedback.

A reset-phase strobe clears the flag, but only while the active-low clear-errors input is asserted. A clear and a load in the same cycle resolve in favour of the clear. The flag is always visible on its own output. It is also placed on one bit of a 16-bit result bus whenever the active-low result select is asserted.

Top module: `input_parity_flag`

## Requirements
- R1: The check covers the 16 registered data bits and the registered parity bit, 17 bits in all, with odd parity. A parity error means an even count of ones, so all-zero data with a zero parity bit is an error.
- R2: Data and parity are each captured in a register on every clock. An error-phase load uses the word captured on the previous clock edge, not the word present at the data inputs in the loading cycle.
- R3: When `err_strobe`, `err_clk_en` and `chk_en` are all high, the flag is loaded with the check result on that clock. It goes to 1 on an error and to 0 on a good word.
- R4: When `chk_en` is low, an error-phase strobe leaves the flag unchanged, whatever the word.
- R5: When `err_clk_en` is low, the flag does not change on `err_strobe`, even if a parity error is present.
- R6: `rst_strobe` clears the flag on that clock while `clr_err_n` is 0. While `clr_err_n` is 1, the flag survives `rst_strobe`.
- R7: An enabled clear and an enabled load in the same cycle leave the flag at 0.
- R8: With `res_sel_n` at 0, bit 4 of `res_bus` equals the flag. All other bus bits are always 0, and the whole bus is 0 while `res_sel_n` is 1.
- R9: The asynchronous active-low `rst_n` clears the flag and the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 16 | Input data word |
| par_in | input | 1 | Parity bit accompanying the word |
| chk_en | input | 1 | Enables loading the check result into the flag |
| err_clk_en | input | 1 | Gates the error-phase strobe |
| err_strobe | input | 1 | One-cycle error-phase strobe |
| rst_strobe | input | 1 | One-cycle reset-phase strobe |
| clr_err_n | input | 1 | Active-low qualifier for the reset-phase clear |
| res_sel_n | input | 1 | Active-low result bus select |
| err_flag | output | 1 | Sticky parity error flag |
| res_bus | output | 16 | Result bus, flag on bit 4 |

## Verification
The hardest situation to reach is a flag that must hold a stale value while the current word disagrees with it. The stimulus first sets the flag with an erroneous word. It then presents a good word while checking is disabled, and later a bad word while the error-clock gate is closed. Both show that the flag keeps its prior state.

The registered-word rule is reached by changing the data in the same cycle as the strobe. A combined clear-and-load strobe covers the priority rule.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
   localparam int unsigned IPF_DATA_W   = 16;
   localparam int unsigned IPF_BUS_W    = 16;
   localparam int unsigned IPF_FLAG_POS = 4;
   typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_sense_e;
endpackage

// File: rtl/ipf_capture.sv
module ipf_capture #(
   parameter int unsigned DATA_W = ipf_pkg::IPF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_in,
   input  logic              par_in,
   output logic [DATA_W-1:0] data_q,
   output logic              par_q
);
   if (DATA_W < 1) begin : g_bad_w
      $error("ipf_capture: DATA_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= data_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_q <= 1'b0;
      else        par_q <= par_in;
   end

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (data_q == $past(data_in)) && (par_q == $past(par_in)));
endmodule

// File: rtl/ipf_parity.sv
module ipf_parity #(
   parameter int unsigned        DATA_W = ipf_pkg::IPF_DATA_W,
   parameter ipf_pkg::par_sense_e SENSE = ipf_pkg::PAR_ODD
) (
   input  logic [DATA_W-1:0] data_q,
   input  logic              par_q,
   output logic              perr
);
   localparam int unsigned CHK_W = DATA_W + 1;
   logic [CHK_W-1:0] chk_word;
   assign chk_word = {data_q, par_q};

   if (SENSE == ipf_pkg::PAR_ODD) begin : g_odd
      assign perr = ~(^chk_word);
   end else begin : g_even
      assign perr = ^chk_word;
   end

   always_comb begin
      p_parity_r1: assert (perr == (($countones(chk_word) % 2) == ((SENSE == ipf_pkg::PAR_ODD) ? 0 : 1)));
   end
endmodule

// File: rtl/ipf_flag.sv
module ipf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic perr,
   input  logic chk_en,
   input  logic err_clk_en,
   input  logic err_strobe,
   input  logic rst_strobe,
   input  logic clr_err_n,
   output logic flag
);
   logic do_clear;
   logic do_err;
   logic next_err;

   assign do_clear = rst_strobe & ~clr_err_n;
   assign do_err   = err_strobe & err_clk_en;
   assign next_err = chk_en ? perr : flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (do_clear) flag <= 1'b0;
      else if (do_err)   flag <= next_err;
   end

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe && err_clk_en && chk_en && !(rst_strobe && !clr_err_n)) |=> (flag == $past(perr)));
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en && !(rst_strobe && !clr_err_n)) |=> $stable(flag));
   p_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(err_strobe && err_clk_en) && !(rst_strobe && !clr_err_n)) |=> $stable(flag));
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_strobe && !clr_err_n) |=> !flag);
   p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_strobe && !clr_err_n && err_strobe && err_clk_en && chk_en && perr) |=> !flag);
endmodule

// File: rtl/ipf_result.sv
module ipf_result #(
   parameter int unsigned BUS_W    = ipf_pkg::IPF_BUS_W,
   parameter int unsigned FLAG_POS = ipf_pkg::IPF_FLAG_POS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flag,
   input  logic             res_sel_n,
   output logic [BUS_W-1:0] res_bus
);
   if (FLAG_POS >= BUS_W) begin : g_bad_pos
      $error("ipf_result: FLAG_POS must lie inside the bus");
   end

   for (genvar b = 0; b < BUS_W; b++) begin : g_bit
      if (b == FLAG_POS) begin : g_flag
         assign res_bus[b] = flag & ~res_sel_n;
      end else begin : g_zero
         assign res_bus[b] = 1'b0;
      end
   end

   p_bus_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_sel_n |-> (res_bus == '0));
   p_bus_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_sel_n |-> ($countones(res_bus) == (flag ? 1 : 0)) && (res_bus[FLAG_POS] == flag));
endmodule

// File: rtl/input_parity_flag.sv
module input_parity_flag #(
   parameter int unsigned         DATA_W   = ipf_pkg::IPF_DATA_W,
   parameter int unsigned         BUS_W    = ipf_pkg::IPF_BUS_W,
   parameter int unsigned         FLAG_POS = ipf_pkg::IPF_FLAG_POS,
   parameter ipf_pkg::par_sense_e SENSE    = ipf_pkg::PAR_ODD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_in,
   input  logic              par_in,
   input  logic              chk_en,
   input  logic              err_clk_en,
   input  logic              err_strobe,
   input  logic              rst_strobe,
   input  logic              clr_err_n,
   input  logic              res_sel_n,
   output logic              err_flag,
   output logic [BUS_W-1:0]  res_bus
);
   logic [DATA_W-1:0] data_q;
   logic              par_q;
   logic              perr;

   ipf_capture #(.DATA_W(DATA_W)) i_capture (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .par_in(par_in),
      .data_q(data_q), .par_q(par_q));

   ipf_parity #(.DATA_W(DATA_W), .SENSE(SENSE)) i_parity (
      .data_q(data_q), .par_q(par_q), .perr(perr));

   ipf_flag i_flag (
      .clk(clk), .rst_n(rst_n), .perr(perr), .chk_en(chk_en),
      .err_clk_en(err_clk_en), .err_strobe(err_strobe),
      .rst_strobe(rst_strobe), .clr_err_n(clr_err_n), .flag(err_flag));

   ipf_result #(.BUS_W(BUS_W), .FLAG_POS(FLAG_POS)) i_result (
      .clk(clk), .rst_n(rst_n), .flag(err_flag), .res_sel_n(res_sel_n),
      .res_bus(res_bus));

   p_reset_r9: assert property (@(posedge clk) $rose(rst_n) |-> !err_flag);
endmodule

// File: tb/test_input_parity_flag.sv
module test_input_parity_flag;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] data_in = '0;
   logic        par_in = 1'b0;
   logic        chk_en = 1'b1;
   logic        err_clk_en = 1'b1;
   logic        err_strobe = 1'b0;
   logic        rst_strobe = 1'b0;
   logic        clr_err_n = 1'b1;
   logic        res_sel_n = 1'b0;
   logic        err_flag;
   logic [15:0] res_bus;
   int          n_run = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   input_parity_flag i_input_parity_flag (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .par_in(par_in),
      .chk_en(chk_en), .err_clk_en(err_clk_en), .err_strobe(err_strobe),
      .rst_strobe(rst_strobe), .clr_err_n(clr_err_n), .res_sel_n(res_sel_n),
      .err_flag(err_flag), .res_bus(res_bus));

   // {data, parity, expected flag}; flag = 1 when the 17-bit count of ones is even
   localparam logic [17:0] VEC [10] = '{
      {16'h0000, 1'b0, 1'b1}, {16'h0000, 1'b1, 1'b0},
      {16'h0001, 1'b0, 1'b0}, {16'h0003, 1'b0, 1'b1},
      {16'h0003, 1'b1, 1'b0}, {16'hFFFF, 1'b0, 1'b1},
      {16'hFFFF, 1'b1, 1'b0}, {16'h8000, 1'b1, 1'b1},
      {16'h1234, 1'b0, 1'b0}, {16'hA5A5, 1'b1, 1'b0}};

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply_word(input logic [15:0] d, input logic p);
      @(negedge clk); data_in = d; par_in = p;
      @(negedge clk); err_strobe = 1'b1;
      @(negedge clk); err_strobe = 1'b0;
   endtask

   task automatic reset_strobe();
      @(negedge clk); rst_strobe = 1'b1;
      @(negedge clk); rst_strobe = 1'b0;
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset flag", {15'd0, err_flag}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R8: vector table
      for (int i = 0; i < 10; i++) begin
         apply_word(VEC[i][17:2], VEC[i][1]);
         check("R1/R3 flag", {15'd0, err_flag}, {15'd0, VEC[i][0]});
         check("R8 bus", res_bus, {11'd0, VEC[i][0], 4'd0});
      end

      // R8: deselected bus is zero while flag is set
      apply_word(16'h0000, 1'b0);
      res_sel_n = 1'b1; #1;
      check("R8 deselect", res_bus, 16'd0);
      check("R8 flag held", {15'd0, err_flag}, 16'd1);
      res_sel_n = 1'b0;

      // R4: checking disabled, good word does not clear the flag
      chk_en = 1'b0;
      apply_word(16'h0000, 1'b1);
      check("R4 hold set", {15'd0, err_flag}, 16'd1);
      chk_en = 1'b1;
      apply_word(16'h0000, 1'b1);
      check("R3 clear by good word", {15'd0, err_flag}, 16'd0);
      chk_en = 1'b0;
      apply_word(16'h0000, 1'b0);
      check("R4 hold clear", {15'd0, err_flag}, 16'd0);
      chk_en = 1'b1;

      // R5: gate closed, bad word does not set the flag
      err_clk_en = 1'b0;
      apply_word(16'h0003, 1'b0);
      check("R5 gated", {15'd0, err_flag}, 16'd0);
      err_clk_en = 1'b1;

      // R2: data change in the strobe cycle is not seen by the load
      @(negedge clk); data_in = 16'h0001; par_in = 1'b0;
      @(negedge clk); data_in = 16'h0000; par_in = 1'b0; err_strobe = 1'b1;
      @(negedge clk); err_strobe = 1'b0;
      check("R2 registered word", {15'd0, err_flag}, 16'd0);
      @(negedge clk); err_strobe = 1'b1;
      @(negedge clk); err_strobe = 1'b0;
      check("R2 next word", {15'd0, err_flag}, 16'd1);

      // R6: clear qualified by clr_err_n
      clr_err_n = 1'b1;
      reset_strobe();
      check("R6 survives", {15'd0, err_flag}, 16'd1);
      clr_err_n = 1'b0;
      reset_strobe();
      check("R6 cleared", {15'd0, err_flag}, 16'd0);

      // R7: clear wins over a load of an error
      @(negedge clk); data_in = 16'h0000; par_in = 1'b0;
      @(negedge clk); err_strobe = 1'b1; rst_strobe = 1'b1;
      @(negedge clk); err_strobe = 1'b0; rst_strobe = 1'b0;
      check("R7 clear priority", {15'd0, err_flag}, 16'd0);
      clr_err_n = 1'b1;

      // R9: asynchronous reset mid-run
      apply_word(16'h0000, 1'b0);
      check("R9 pre", {15'd0, err_flag}, 16'd1);
      #3 rst_n = 1'b0; #1;
      check("R9 async clear", {15'd0, err_flag}, 16'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); err_strobe = 1'b1; data_in = 16'h0001;
      @(negedge clk); err_strobe = 1'b0;
      check("R9 capture cleared", {15'd0, err_flag}, 16'd1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule